// File: doc/BRIEF.md
# ATA PIO Cycle Timing Selector

This block sits between a host's register interface and a parallel ATA device bus. For every access to the device register space it chooses a timing word, copies the four cycle counts in that word, and runs the access through four phases in fixed order: address setup, strobe active, data hold and end-of-cycle recovery. The strobe output is high only during the strobe-active phase. A single-cycle done pulse marks the end of the access.

The timing word comes from one of three 32-bit inputs. The common word covers most accesses. On the faster core variants, an access to the data register uses one of two per-device words instead. The block chooses between those two with a drive-select flag. It keeps that flag by watching accepted writes to the drive/head register. The timing registers themselves live outside this block and are presented on its inputs.

A request is accepted only when the controller enable is high and no access is running. A request that is not accepted has no effect at all.

Top module: `ata_pio_timing_sel`

## Requirements
- R1: A timing word packs four unsigned FIELD_W-bit cycle counts. Bits [FIELD_W-1:0] hold the setup count and the next field up holds the strobe-active count. Above that comes the hold count, and the top field holds the recovery count. With FIELD_W=8 these are bits 7:0, 15:8, 23:16 and 31:24.
- R2: With VARIANT greater than 1, an accepted access to address DATA_ADDR (default 0) takes the per-device word `tim_fast1` when `dev_sel` is 1 and `tim_fast0` when `dev_sel` is 0. `dev_sel` is sampled at acceptance.
- R3: An accepted access to any other address takes `tim_common`. With VARIANT equal to 1, every access takes `tim_common`.
- R4: An accepted write to address DEVHEAD_ADDR (default 6) loads `dev_sel` from bit DEV_BIT (default 4) of `req_wdata`. Reads, and writes to other addresses, leave `dev_sel` unchanged.
- R5: After reset, `busy`, `strobe`, `done` and `dev_sel` are all 0.
- R6: While `ide_enable` is 0, no request is accepted. `busy` stays low, no `done` pulse appears and `dev_sel` does not change.
- R7: The phases run in this order: setup, strobe active, hold, recovery. `strobe` goes high only after the setup phase and stays high exactly for the strobe-active phase.
- R8: Each phase lasts its field value plus one clock, so `busy` stays high for setup+active+hold+recovery+4 clocks. An all-zero word gives 4 clocks.
- R9: The fields are captured on the acceptance edge. Changes to any timing input during an access do not alter that access.
- R10: `done` is a one-clock pulse in the first cycle after `busy` falls. A request made while `busy` is high is ignored, and this includes any drive/head write it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ide_enable | input | 1 | Controller enable; 0 blocks every new access |
| req_valid | input | 1 | Device-space access request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Device register address |
| req_wdata | input | DATA_W | Write data, snooped for the drive-select bit |
| tim_common | input | 4*FIELD_W | Common PIO timing word |
| tim_fast0 | input | 4*FIELD_W | Fast timing word for drive 0 |
| tim_fast1 | input | 4*FIELD_W | Fast timing word for drive 1 |
| busy | output | 1 | Access in progress |
| strobe | output | 1 | Read/write strobe, high in the strobe-active phase |
| done | output | 1 | One-clock end-of-access pulse |
| dev_sel | output | 1 | Tracked drive-select flag |

## Verification
The bench builds two copies of the block with default widths and addresses. One copy has VARIANT=2, which makes the per-device selection and the drive-select tracking reachable. The other has VARIANT=1, where the data register must fall back to the common word. Small distinct field values in each timing word make a wrong field, a wrong word or a phase-length error show up as a different setup, strobe or total length. An all-zero word exercises the minimum length.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

   localparam int PIO_NUM_FIELDS = 4;

   localparam int FLD_SETUP  = 0;
   localparam int FLD_ACTIVE = 1;
   localparam int FLD_HOLD   = 2;
   localparam int FLD_RECOV  = 3;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_ACTIVE = 3'd2,
      PH_HOLD   = 3'd3,
      PH_RECOV  = 3'd4
   } pio_phase_e;

   function automatic pio_phase_e phase_after(input pio_phase_e p);
      case (p)
         PH_SETUP:  return PH_ACTIVE;
         PH_ACTIVE: return PH_HOLD;
         PH_HOLD:   return PH_RECOV;
         default:   return PH_IDLE;
      endcase
   endfunction

   function automatic logic [1:0] phase_field(input pio_phase_e p);
      case (p)
         PH_ACTIVE: return 2'(FLD_ACTIVE);
         PH_HOLD:   return 2'(FLD_HOLD);
         PH_RECOV:  return 2'(FLD_RECOV);
         default:   return 2'(FLD_SETUP);
      endcase
   endfunction

endpackage

// File: rtl/pio_devsel_tracker.sv
module pio_devsel_tracker #(
   parameter int ADDR_W       = 4,
   parameter int DATA_W       = 8,
   parameter int DEVHEAD_ADDR = 6,
   parameter int DEV_BIT      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              dev_sel
);

   localparam logic [ADDR_W-1:0] HEAD_A = ADDR_W'(DEVHEAD_ADDR);

   logic hit;
   assign hit = accept && wr && (addr == HEAD_A);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dev_sel <= 1'b0;
      else if (hit) dev_sel <= wdata[DEV_BIT];
   end

   AST_DEVSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(dev_sel)); // R4

   AST_DEVSEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> dev_sel == $past(wdata[DEV_BIT])); // R4

endmodule

// File: rtl/pio_timing_mux.sv
module pio_timing_mux #(
   parameter int VARIANT   = 2,
   parameter int ADDR_W    = 4,
   parameter int WORD_W    = 32,
   parameter int DATA_ADDR = 0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              dev_sel,
   input  logic [WORD_W-1:0] common,
   input  logic [WORD_W-1:0] fast0,
   input  logic [WORD_W-1:0] fast1,
   output logic [WORD_W-1:0] word
);

   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

   generate
      if (VARIANT == 1) begin : g_common_only
         logic unused_fast;
         assign unused_fast = ^{fast0, fast1, dev_sel, addr};
         assign word = common;
      end else begin : g_per_device
         logic [WORD_W-1:0] dev_word;
         assign dev_word = dev_sel ? fast1 : fast0;
         assign word     = (addr == DATA_A) ? dev_word : common;
      end
   endgenerate

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
   import ata_pio_pkg::*;
#(
   parameter int FIELD_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [4*FIELD_W-1:0]   word,
   output logic                   busy,
   output logic                   strobe,
   output logic                   done
);

   logic [PIO_NUM_FIELDS-1:0][FIELD_W-1:0] fld_in;
   logic [PIO_NUM_FIELDS-1:0][FIELD_W-1:0] lat_q;
   pio_phase_e                             phase_q;
   logic [FIELD_W-1:0]                     cnt_q;
   logic                                   done_q;

   genvar gi;
   generate
      for (gi = 0; gi < PIO_NUM_FIELDS; gi++) begin : g_unpack
         assign fld_in[gi] = word[gi*FIELD_W +: FIELD_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
         lat_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (phase_q == PH_IDLE) begin
            if (start) begin
               lat_q   <= fld_in;
               phase_q <= PH_SETUP;
               cnt_q   <= fld_in[FLD_SETUP];
            end
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end else if (phase_q == PH_RECOV) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
         end else begin
            phase_q <= phase_after(phase_q);
            cnt_q   <= lat_q[phase_field(phase_after(phase_q))];
         end
      end
   end

   assign busy   = (phase_q != PH_IDLE);
   assign strobe = (phase_q == PH_ACTIVE);
   assign done   = done_q;

   AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(lat_q)); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

   AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R10

   AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> $past(busy)); // R7

   AST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe) |-> phase_q == PH_HOLD); // R7

endmodule

// File: rtl/ata_pio_timing_sel.sv
module ata_pio_timing_sel #(
   parameter int VARIANT      = 2,
   parameter int FIELD_W      = 8,
   parameter int ADDR_W       = 4,
   parameter int DATA_W       = 8,
   parameter int DATA_ADDR    = 0,
   parameter int DEVHEAD_ADDR = 6,
   parameter int DEV_BIT      = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ide_enable,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   input  logic [4*FIELD_W-1:0] tim_common,
   input  logic [4*FIELD_W-1:0] tim_fast0,
   input  logic [4*FIELD_W-1:0] tim_fast1,
   output logic                 busy,
   output logic                 strobe,
   output logic                 done,
   output logic                 dev_sel
);

   localparam int WORD_W = 4 * FIELD_W;

   generate
      if (VARIANT < 1 || VARIANT > 3) begin : g_bad_variant
         $error("VARIANT must be 1, 2 or 3");
      end
      if (DEV_BIT >= DATA_W) begin : g_bad_devbit
         $error("DEV_BIT outside write data");
      end
      if (DATA_ADDR == DEVHEAD_ADDR) begin : g_bad_addr
         $error("data and drive/head addresses must differ");
      end
      if (DATA_ADDR >= (1 << ADDR_W) || DEVHEAD_ADDR >= (1 << ADDR_W)) begin : g_bad_range
         $error("register address exceeds ADDR_W");
      end
      if (FIELD_W < 1) begin : g_bad_field
         $error("FIELD_W must be positive");
      end
   endgenerate

   logic              accept;
   logic [WORD_W-1:0] sel_word;

   assign accept = req_valid && ide_enable && !busy;

   pio_devsel_tracker #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .DEVHEAD_ADDR(DEVHEAD_ADDR), .DEV_BIT(DEV_BIT)
   ) u_track (
      .clk(clk), .rst_n(rst_n), .accept(accept), .wr(req_write),
      .addr(req_addr), .wdata(req_wdata), .dev_sel(dev_sel)
   );

   pio_timing_mux #(
      .VARIANT(VARIANT), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .DATA_ADDR(DATA_ADDR)
   ) u_mux (
      .addr(req_addr), .dev_sel(dev_sel), .common(tim_common),
      .fast0(tim_fast0), .fast1(tim_fast1), .word(sel_word)
   );

   pio_phase_seq #(.FIELD_W(FIELD_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(accept), .word(sel_word),
      .busy(busy), .strobe(strobe), .done(done)
   );

   AST_NO_START_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !ide_enable) |=> !busy); // R6

   AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> busy); // R7

endmodule

// File: tb/ata_pio_timing_sel_bench.sv
module ata_pio_timing_sel_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ide_enable = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_valid_v1 = 1'b0;
   logic        req_write = 1'b0;
   logic [3:0]  req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic [31:0] tim_common, tim_fast0, tim_fast1;
   logic        busy_m, strobe_m, done_m, sel_m;
   logic        busy_v, strobe_v, done_v, sel_v;

   int checks = 0;
   int fails  = 0;
   logic [31:0] q_m[$];
   logic [31:0] q_v[$];
   logic model_sel = 1'b0;

   localparam logic [31:0] W_COMMON = {8'd3, 8'd1, 8'd5, 8'd2};
   localparam logic [31:0] W_FAST0  = {8'd2, 8'd0, 8'd3, 8'd1};
   localparam logic [31:0] W_FAST1  = 32'h0;
   localparam logic [31:0] W_ALT    = {8'd0, 8'd4, 8'd1, 8'd9};

   always #2 clk = ~clk;

   ata_pio_timing_sel #(.VARIANT(2)) u_ata_pio_timing_sel (
      .clk(clk), .rst_n(rst_n), .ide_enable(ide_enable), .req_valid(req_valid),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .tim_common(tim_common), .tim_fast0(tim_fast0), .tim_fast1(tim_fast1),
      .busy(busy_m), .strobe(strobe_m), .done(done_m), .dev_sel(sel_m));

   ata_pio_timing_sel #(.VARIANT(1)) u_ata_pio_timing_sel_v1 (
      .clk(clk), .rst_n(rst_n), .ide_enable(ide_enable), .req_valid(req_valid_v1),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .tim_common(tim_common), .tim_fast0(tim_fast0), .tim_fast1(tim_fast1),
      .busy(busy_v), .strobe(strobe_v), .done(done_v), .dev_sel(sel_v));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // R1 field positions: setup [7:0], active [15:8], hold [23:16], recovery [31:24]
   task automatic compare(input string who, input logic [31:0] w,
                          input int pre, input int str, input int tot);
      check({who, " R7 setup length"}, pre, int'(w[7:0]) + 1);
      check({who, " R7 strobe length"}, str, int'(w[15:8]) + 1);
      check({who, " R8 busy length"}, tot,
            int'(w[7:0]) + int'(w[15:8]) + int'(w[23:16]) + int'(w[31:24]) + 4);
   endtask

   int pre_m = 0, str_m = 0, tot_m = 0;
   always @(negedge clk) begin
      if (busy_m) begin
         tot_m++;
         if (strobe_m) str_m++;
         else if (str_m == 0) pre_m++;
      end
      if (done_m) begin
         if (q_m.size() == 0) check("R10 unexpected done (main)", 1, 0);
         else compare("main", q_m.pop_front(), pre_m, str_m, tot_m);
         pre_m = 0; str_m = 0; tot_m = 0;
      end
   end

   int pre_v = 0, str_v = 0, tot_v = 0;
   always @(negedge clk) begin
      if (busy_v) begin
         tot_v++;
         if (strobe_v) str_v++;
         else if (str_v == 0) pre_v++;
      end
      if (done_v) begin
         if (q_v.size() == 0) check("R10 unexpected done (v1)", 1, 0);
         else compare("v1 R3", q_v.pop_front(), pre_v, str_v, tot_v);
         pre_v = 0; str_v = 0; tot_v = 0;
      end
   end

   task automatic issue(input logic wr, input logic [3:0] a, input logic [7:0] d,
                        input bit to_v1);
      @(negedge clk);
      while (busy_m || busy_v) @(negedge clk);
      req_write = wr; req_addr = a; req_wdata = d;
      req_valid = 1'b1; req_valid_v1 = to_v1;
      // R2/R3: data register uses per-device word on the main instance
      q_m.push_back((a == 4'd0) ? (model_sel ? tim_fast1 : tim_fast0) : tim_common);
      if (to_v1) q_v.push_back(tim_common);
      if (wr && a == 4'd6) model_sel = d[4];
      @(negedge clk);
      req_valid = 1'b0; req_valid_v1 = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy_m || busy_v) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      tim_common = W_COMMON; tim_fast0 = W_FAST0; tim_fast1 = W_FAST1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 reset state
      check("R5 busy", int'(busy_m), 0);
      check("R5 strobe", int'(strobe_m), 0);
      check("R5 done", int'(done_m), 0);
      check("R5 dev_sel", int'(sel_m), 0);
      check("R5 v1 busy", int'(busy_v), 0);

      ide_enable = 1'b1;
      issue(1'b0, 4'd2, 8'h00, 1'b1);           // R3 common word
      issue(1'b0, 4'd0, 8'h00, 1'b1);           // R2 fast0, R3 on v1
      issue(1'b1, 4'd6, 8'h10, 1'b1);           // R4 select drive 1
      check("R4 dev_sel set", int'(sel_m), 1);
      issue(1'b1, 4'd0, 8'h00, 1'b1);           // R2 fast1, R8 zero fields
      issue(1'b1, 4'd3, 8'h00, 1'b1);           // R4 other address
      check("R4 other address keeps dev_sel", int'(sel_m), 1);
      issue(1'b0, 4'd6, 8'h00, 1'b1);           // R4 read of drive/head
      check("R4 read keeps dev_sel", int'(sel_m), 1);
      issue(1'b1, 4'd6, 8'hEF, 1'b1);
      check("R4 dev_sel cleared", int'(sel_m), 0);
      issue(1'b0, 4'd0, 8'h00, 1'b1);           // R2 back to fast0
      wait_idle();

      // R6: disabled controller accepts nothing
      ide_enable = 1'b0;
      req_write = 1'b1; req_addr = 4'd6; req_wdata = 8'h10;
      req_valid = 1'b1; req_valid_v1 = 1'b1;
      @(negedge clk);
      req_addr = 4'd0;
      @(negedge clk);
      req_valid = 1'b0; req_valid_v1 = 1'b0;
      check("R6 busy stays low", int'(busy_m), 0);
      check("R6 v1 busy stays low", int'(busy_v), 0);
      check("R6 dev_sel unchanged", int'(sel_m), 0);
      repeat (3) @(negedge clk);
      ide_enable = 1'b1;

      // R10: request during busy ignored
      issue(1'b0, 4'd1, 8'h00, 1'b0);
      req_write = 1'b1; req_addr = 4'd6; req_wdata = 8'h10; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 busy request ignored, dev_sel", int'(sel_m), 0);
      wait_idle();

      // R9: timing change mid-access does not alter it
      issue(1'b0, 4'd2, 8'h00, 1'b1);
      @(negedge clk);
      tim_common = W_ALT;
      wait_idle();
      // R1: another field pattern on the common word
      issue(1'b0, 4'd5, 8'h00, 1'b1);
      wait_idle();
      tim_common = W_COMMON;

      repeat (4) @(negedge clk);
      check("R10 all main accesses completed", q_m.size(), 0);
      check("R10 all v1 accesses completed", q_v.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule